// File: doc/BRIEF.md
# Video Interrupt Controller with Source Muxing

This block gathers event lines from the two video paths of a video processing chip into one interrupt pin. The two paths are the processor path and the decoder path. Around them sit four vertical-sync candidates, a timer overflow pair, a line-buffer error pair with a field indicator, an extra processor-path error, a decoder horizontal-lock indication and a general auxiliary event. Every input may come from another clock domain, so each one passes through a synchroniser. A routing stage then picks the signal that feeds each of eight vectors, and the rising edge of that signal latches the vector's flag.

A host reaches the block through a byte-wide register port. Writes take effect at the clock edge that samples them. A read returns its data one clock later. Each vector has a mask bit and an arm bit. A 0 in the arm bit clears that flag and keeps it clear. A 1 lets new events in again. The pin signals either a level or a one-clock pulse, in either polarity.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: A flag bit at address 0 sets when its routed source rises while its arm bit (address 2) is 1. The flag reads 1 from the third rising clock edge after the input change, with the default synchroniser depth of 2.
- R3: Writing 0 to an arm bit clears that flag at the write edge. An event that would set the flag at that same edge is lost.
- R4: In level mode (address 3 bit 0 = 0), `irq_o` is active while any flag is set with its mask bit (address 1) at 0. A mask bit of 1 hides that flag from the pin but leaves the flag set. Address 3 bit 1 = 1 makes the active level low. A mask or polarity write affects the pin from the following edge.
- R5: In pulse mode (address 3 bit 0 = 1), `irq_o` sits at its idle level: low, or high when bit 1 = 1. It leaves that level for exactly one clock at the edge where an unmasked flag newly sets.
- R6: Address 4 bit 0 feeds vectors 0 and 1 from the decoder-path event lines instead of the processor path. Address 4 bit 1 does the same for vector 2 (the mode-change lines).
- R7: Vector 3 takes a sync line chosen by address 4 bits [3:2]: 0 input sync, 1 output sync, 2 decoder sync, 3 serial-bus detect. Address 4 bit 4 inverts the chosen line.
- R8: Address 4 bit 5 feeds vectors 4 and 5 from line-buffer errors instead of timer overflows. A line-buffer error counts only while the field indicator equals address 4 bit 7 (0 odd, 1 even). Address 4 bit 6 ORs the processor-path error into vector 5.
- R9: Vector 6 is the decoder horizontal-lock line, gated by address 5 bit 0. Vector 7 is the auxiliary event.
- R10: Reads return data one edge after the request. Writes to address 0 are ignored. Bits with no storage read 0, and so do addresses 6 to 15.
- R11: A set flag stays set, even after its source falls, until a 0 is written to its arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data, valid one clock after the strobe |
| proc_sig_i | input | 2 | Processor-path events for vectors 0 and 1 |
| dec_sig_i | input | 2 | Decoder-path events for vectors 0 and 1 |
| proc_mode_i | input | 1 | Processor-path mode change |
| dec_mode_i | input | 1 | Decoder-path mode change |
| vs_in_i | input | 1 | Input vertical sync |
| vs_out_i | input | 1 | Output vertical sync |
| vs_dec_i | input | 1 | Decoder vertical sync |
| vs_bus_i | input | 1 | Serial-bus detect event |
| tmr_ovf_i | input | 2 | Timer overflows for vectors 4 and 5 |
| lb_err_i | input | 2 | Line-buffer errors for vectors 4 and 5 |
| lb_field_even_i | input | 1 | Current field is even |
| proc_err_i | input | 1 | Extra processor-path error |
| dec_hlock_i | input | 1 | Decoder horizontal lock |
| aux_i | input | 1 | Auxiliary event for vector 7 |
| irq_o | output | 1 | Interrupt pin |

## Verification
An input change applied between edges passes two synchroniser flops. It then meets the edge detector and reaches the flag and the registered pin together at the third rising edge, which is also when a read first shows it. A mask, polarity or mode write changes the pin one edge after the write edge. Read data appears one edge after the read strobe.

The bench drives on the falling edge and steps a cycle model at each rising edge. It compares on the next falling edge, and its directed checks count steps to those same edges.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int NVEC = 8;
   localparam int DW   = 8;

   typedef enum logic [2:0] {
      REG_FLAG  = 3'd0,
      REG_MASK  = 3'd1,
      REG_ARM   = 3'd2,
      REG_PIN   = 3'd3,
      REG_ROUTE = 3'd4,
      REG_LOCK  = 3'd5
   } vic_reg_e;

   localparam int RT_V01_DEC = 0;
   localparam int RT_V2_DEC  = 1;
   localparam int RT_VS_LO   = 2;
   localparam int RT_VS_INV  = 4;
   localparam int RT_V45_LB  = 5;
   localparam int RT_PERR_EN = 6;
   localparam int RT_LB_EVEN = 7;

   typedef struct packed {
      logic       aux;
      logic       dec_hlock;
      logic       proc_err;
      logic       lb_field_even;
      logic [1:0] lb_err;
      logic [1:0] tmr_ovf;
      logic       vs_bus;
      logic       vs_dec;
      logic       vs_out;
      logic       vs_in;
      logic       dec_mode;
      logic       proc_mode;
      logic [1:0] dec_sig;
      logic [1:0] proc_sig;
   } vic_src_t;

   typedef struct packed {
      logic active_low;
      logic pulse_mode;
   } vic_pin_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("vic_sync: WIDTH must be positive");
   end
   if (STAGES == 1 || STAGES < 0) begin : g_bad_depth
      $error("vic_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q <= '0;
         else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
      assign q_o = stage_q[STAGES-1];
   end
endmodule

// File: rtl/vic_route.sv
module vic_route
   import vic_pkg::*;
(
   input  vic_src_t        src_i,
   input  logic [DW-1:0]   route_i,
   input  logic            hlock_en_i,
   output logic [NVEC-1:0] vec_o
);
   logic [3:0] vs_pick;
   logic       vs_sel;
   logic       field_ok;
   logic [1:0] lb_hit;
   logic [1:0] err_pair;

   assign vs_pick  = {src_i.vs_bus, src_i.vs_dec, src_i.vs_out, src_i.vs_in};
   assign vs_sel   = vs_pick[route_i[RT_VS_LO +: 2]];
   assign field_ok = (src_i.lb_field_even == route_i[RT_LB_EVEN]);
   assign lb_hit   = src_i.lb_err & {2{field_ok}};
   assign err_pair = route_i[RT_V45_LB] ? lb_hit : src_i.tmr_ovf;

   for (genvar i = 0; i < 2; i++) begin : g_sig
      assign vec_o[i] = route_i[RT_V01_DEC] ? src_i.dec_sig[i] : src_i.proc_sig[i];
   end

   assign vec_o[2] = route_i[RT_V2_DEC] ? src_i.dec_mode : src_i.proc_mode;
   assign vec_o[3] = vs_sel ^ route_i[RT_VS_INV];
   assign vec_o[4] = err_pair[0];
   assign vec_o[5] = err_pair[1] | (route_i[RT_PERR_EN] & src_i.proc_err);
   assign vec_o[6] = hlock_en_i & src_i.dec_hlock;
   assign vec_o[7] = src_i.aux;
endmodule

// File: rtl/vic_regs.sv
module vic_regs
   import vic_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [NVEC-1:0]   flags_i,
   output logic [NVEC-1:0]   mask_o,
   output logic [NVEC-1:0]   arm_o,
   output logic [NVEC-1:0]   arm_nxt_o,
   output vic_pin_t          pin_cfg_o,
   output logic [DW-1:0]     route_o,
   output logic              hlock_en_o,
   output logic [DW-1:0]     rdata_o
);
   localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(REG_FLAG);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(REG_MASK);
   localparam logic [ADDR_W-1:0] A_ARM   = ADDR_W'(REG_ARM);
   localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(REG_PIN);
   localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(REG_ROUTE);
   localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(REG_LOCK);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("vic_regs: ADDR_W must cover six registers");
   end

   logic [NVEC-1:0] mask_q, arm_q;
   vic_pin_t        pin_q;
   logic [DW-1:0]   route_q;
   logic            lock_q;
   logic [DW-1:0]   rd_mux, rdata_q;

   always_comb begin
      arm_nxt_o = arm_q;
      if (wr_i && addr_i == A_ARM) arm_nxt_o = wdata_i[NVEC-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q  <= '0;
         arm_q   <= '0;
         pin_q   <= '0;
         route_q <= '0;
         lock_q  <= 1'b0;
      end else begin
         arm_q <= arm_nxt_o;
         if (wr_i) begin
            if (addr_i == A_MASK)  mask_q  <= wdata_i[NVEC-1:0];
            if (addr_i == A_PIN)   pin_q   <= wdata_i[1:0];
            if (addr_i == A_ROUTE) route_q <= wdata_i;
            if (addr_i == A_LOCK)  lock_q  <= wdata_i[0];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if      (addr_i == A_FLAG)  rd_mux[NVEC-1:0] = flags_i;
      else if (addr_i == A_MASK)  rd_mux[NVEC-1:0] = mask_q;
      else if (addr_i == A_ARM)   rd_mux[NVEC-1:0] = arm_q;
      else if (addr_i == A_PIN)   rd_mux[1:0]      = pin_q;
      else if (addr_i == A_ROUTE) rd_mux           = route_q;
      else if (addr_i == A_LOCK)  rd_mux[0]        = lock_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_mux;
   end

   assign mask_o     = mask_q;
   assign arm_o      = arm_q;
   assign pin_cfg_o  = pin_q;
   assign route_o    = route_q;
   assign hlock_en_o = lock_q;
   assign rdata_o    = rdata_q;

   p_unimpl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i > A_LOCK) |=> rdata_o == '0);
   p_pin_pad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == A_PIN) |=> rdata_o[DW-1:2] == '0);
   p_read_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |=> $stable(rdata_o));
   p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == A_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/vic_core.sv
module vic_core
   import vic_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NVEC-1:0] src_i,
   input  logic [NVEC-1:0] mask_i,
   input  logic [NVEC-1:0] arm_i,
   input  logic [NVEC-1:0] arm_nxt_i,
   input  vic_pin_t        pin_cfg_i,
   output logic [NVEC-1:0] flags_o,
   output logic            irq_o
);
   logic [NVEC-1:0] prev_q, flag_q, flag_d, rise, fresh;
   logic            req_level, req_pulse, pin_d, pin_q;

   assign rise      = src_i & ~prev_q;
   assign fresh     = rise & arm_i & arm_nxt_i & ~flag_q;
   assign flag_d    = (flag_q | (rise & arm_i)) & arm_nxt_i;
   assign req_level = |(flag_d & ~mask_i);
   assign req_pulse = |(fresh & ~mask_i);
   assign pin_d     = pin_cfg_i.active_low ^ (pin_cfg_i.pulse_mode ? req_pulse : req_level);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         flag_q <= '0;
         pin_q  <= 1'b0;
      end else begin
         prev_q <= src_i;
         flag_q <= flag_d;
         pin_q  <= pin_d;
      end
   end

   assign flags_o = flag_q;
   assign irq_o   = pin_q;

   for (genvar i = 0; i < NVEC; i++) begin : g_vec_chk
      p_set_armed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(flag_q[i]) |-> $past(arm_i[i] && src_i[i]));
      p_clear_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !arm_nxt_i[i] |=> !flag_q[i]);
      p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q[i] && arm_nxt_i[i]) |=> flag_q[i]);
   end

   p_level_pin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_cfg_i.pulse_mode |=>
         irq_o == ($past(pin_cfg_i.active_low) ^ (|(flag_q & ~$past(mask_i)))));
   p_pulse_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_cfg_i.pulse_mode && $past(pin_cfg_i.pulse_mode) && $stable(pin_cfg_i.active_low)
       && irq_o != pin_cfg_i.active_low)
      |-> (|(flag_q & ~$past(flag_q) & ~$past(mask_i))));
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
   import vic_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              host_wr_i,
   input  logic              host_rd_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic [1:0]        proc_sig_i,
   input  logic [1:0]        dec_sig_i,
   input  logic              proc_mode_i,
   input  logic              dec_mode_i,
   input  logic              vs_in_i,
   input  logic              vs_out_i,
   input  logic              vs_dec_i,
   input  logic              vs_bus_i,
   input  logic [1:0]        tmr_ovf_i,
   input  logic [1:0]        lb_err_i,
   input  logic              lb_field_even_i,
   input  logic              proc_err_i,
   input  logic              dec_hlock_i,
   input  logic              aux_i,
   output logic              irq_o
);
   localparam int SRC_W = $bits(vic_src_t);

   if (DATA_W != DW || DATA_W != NVEC) begin : g_bad_data
      $error("vid_irq_ctrl: DATA_W must equal the vector count");
   end

   vic_src_t        raw, syn;
   logic [NVEC-1:0] vec, mask, arm, arm_nxt, flags;
   vic_pin_t        pin_cfg;
   logic [DW-1:0]   route;
   logic            hlock_en;

   assign raw.proc_sig      = proc_sig_i;
   assign raw.dec_sig       = dec_sig_i;
   assign raw.proc_mode     = proc_mode_i;
   assign raw.dec_mode      = dec_mode_i;
   assign raw.vs_in         = vs_in_i;
   assign raw.vs_out        = vs_out_i;
   assign raw.vs_dec        = vs_dec_i;
   assign raw.vs_bus        = vs_bus_i;
   assign raw.tmr_ovf       = tmr_ovf_i;
   assign raw.lb_err        = lb_err_i;
   assign raw.lb_field_even = lb_field_even_i;
   assign raw.proc_err      = proc_err_i;
   assign raw.dec_hlock     = dec_hlock_i;
   assign raw.aux           = aux_i;

   vic_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw),
      .q_o   (syn)
   );

   vic_route u_route (
      .src_i     (syn),
      .route_i   (route),
      .hlock_en_i(hlock_en),
      .vec_o     (vec)
   );

   vic_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (host_wr_i),
      .rd_i      (host_rd_i),
      .addr_i    (host_addr_i),
      .wdata_i   (host_wdata_i),
      .flags_i   (flags),
      .mask_o    (mask),
      .arm_o     (arm),
      .arm_nxt_o (arm_nxt),
      .pin_cfg_o (pin_cfg),
      .route_o   (route),
      .hlock_en_o(hlock_en),
      .rdata_o   (host_rdata_o)
   );

   vic_core u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (vec),
      .mask_i   (mask),
      .arm_i    (arm),
      .arm_nxt_i(arm_nxt),
      .pin_cfg_i(pin_cfg),
      .flags_o  (flags),
      .irq_o    (irq_o)
   );
endmodule

// File: tb/vid_irq_ctrl_test.sv
module vid_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;
   logic [17:0] in_v = '0;

   always #4 clk = ~clk;

   vid_irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n),
      .host_wr_i(wr), .host_rd_i(rd), .host_addr_i(addr),
      .host_wdata_i(wdata), .host_rdata_o(rdata),
      .proc_sig_i(in_v[1:0]), .dec_sig_i(in_v[3:2]),
      .proc_mode_i(in_v[4]), .dec_mode_i(in_v[5]),
      .vs_in_i(in_v[6]), .vs_out_i(in_v[7]), .vs_dec_i(in_v[8]), .vs_bus_i(in_v[9]),
      .tmr_ovf_i(in_v[11:10]), .lb_err_i(in_v[13:12]), .lb_field_even_i(in_v[14]),
      .proc_err_i(in_v[15]), .dec_hlock_i(in_v[16]), .aux_i(in_v[17]),
      .irq_o(irq)
   );

   int n_chk = 0, n_err = 0;
   bit ended = 0;

   logic [17:0] m_s1 = '0, m_s2 = '0;
   logic [7:0]  m_prev = '0, m_flag = '0, m_mask = '0, m_arm = '0, m_route = '0, m_rdata = '0;
   logic [1:0]  m_pin_cfg = '0;
   logic        m_hl = 1'b0, m_pin = 1'b0;
   string       m_rtag = "R1";

   function automatic logic [7:0] f_route(logic [17:0] v, logic [7:0] r, logic hl);
      logic [7:0] s;
      logic [3:0] vs;
      logic       fok;
      vs   = v[9:6];
      fok  = (v[14] == r[7]);
      s[0] = r[0] ? v[2] : v[0];
      s[1] = r[0] ? v[3] : v[1];
      s[2] = r[1] ? v[5] : v[4];
      s[3] = vs[r[3:2]] ^ r[4];
      s[4] = r[5] ? (v[12] & fok) : v[10];
      s[5] = (r[5] ? (v[13] & fok) : v[11]) | (r[6] & v[15]);
      s[6] = hl & v[16];
      s[7] = v[17];
      return s;
   endfunction

   function automatic logic [7:0] f_read(logic [3:0] a);
      case (a)
         4'd0:    return m_flag;
         4'd1:    return m_mask;
         4'd2:    return m_arm;
         4'd3:    return {6'd0, m_pin_cfg};
         4'd4:    return m_route;
         4'd5:    return {7'd0, m_hl};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
      logic [7:0] src, rise, arm_n, fresh, flag_n;
      logic       pin_n;
      src    = f_route(m_s2, m_route, m_hl);
      rise   = src & ~m_prev;
      arm_n  = (w && a == 4'd2) ? d : m_arm;
      fresh  = rise & m_arm & arm_n & ~m_flag;
      flag_n = (m_flag | (rise & m_arm)) & arm_n;
      pin_n  = m_pin_cfg[1] ^ (m_pin_cfg[0] ? |(fresh & ~m_mask) : |(flag_n & ~m_mask));
      if (r) begin
         m_rdata = f_read(a);
         m_rtag  = (a == 4'd0) ? "R2" : "R10";
      end
      if (w) begin
         if (a == 4'd1) m_mask    = d;
         if (a == 4'd3) m_pin_cfg = d[1:0];
         if (a == 4'd4) m_route   = d;
         if (a == 4'd5) m_hl      = d[0];
      end
      m_arm  = arm_n;
      m_prev = src;
      m_s2   = m_s1;
      m_s1   = in_v;
      m_flag = flag_n;
      m_pin  = pin_n;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tg, input string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %02h expected %02h", tg, what, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
      wr = w; rd = r; addr = a; wdata = d;
      @(posedge clk);
      model(w, r, a, d);
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      chk({7'd0, irq}, {7'd0, m_pin}, m_pin_cfg[0] ? "R5" : "R4", "model pin");
      chk(rdata, m_rdata, m_rtag, "model read");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 8'h00);
   endtask

   task automatic wreg(input logic [3:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, a, d);
   endtask

   task automatic rreg(input logic [3:0] a, input logic [7:0] exp, input string tg, input string what);
      step(1'b0, 1'b1, a, 8'h00);
      chk(rdata, exp, tg, what);
   endtask

   task automatic clear_all();
      wreg(4'd2, 8'h00);
      wreg(4'd2, 8'hFF);
   endtask

   task automatic settle();
      in_v = '0;
      idle(4);
   endtask

   task automatic pin_is(input logic exp, input string tg, input string what);
      chk({7'd0, irq}, {7'd0, exp}, tg, what);
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      logic [31:0] t32;
      logic [17:0] flip;
      logic        w, r;
      logic [3:0]  a;
      logic [7:0]  d;
      t32 = $urandom(32'h0BADF00D);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      pin_is(1'b0, "R1", "irq after reset");
      for (int k = 0; k < 6; k++) rreg(4'(k), 8'h00, "R1", "register after reset");

      // R2: latency of a flag and the level pin
      clear_all();
      in_v[0] = 1'b1;
      idle(1); pin_is(1'b0, "R2", "pin one edge after input");
      idle(1); pin_is(1'b0, "R2", "pin two edges after input");
      idle(1); pin_is(1'b1, "R2", "pin three edges after input");
      rreg(4'd0, 8'h01, "R2", "flag from processor line");
      // R11: sticky flag
      in_v[0] = 1'b0;
      idle(4);
      rreg(4'd0, 8'h01, "R11", "flag after source fell");

      // R3: clear and coincident loss
      wreg(4'd2, 8'hFE);
      rreg(4'd0, 8'h00, "R3", "flag after arm 0");
      pin_is(1'b0, "R3", "pin after clear");
      wreg(4'd2, 8'hFF);
      in_v[17] = 1'b1;
      idle(2);
      wreg(4'd2, 8'h7F);
      wreg(4'd2, 8'hFF);
      idle(2);
      rreg(4'd0, 8'h00, "R3", "event at clearing edge lost");

      // R6: path routing
      settle();
      wreg(4'd4, 8'h03);
      clear_all();
      in_v = 18'h00017;
      idle(3);
      rreg(4'd0, 8'h01, "R6", "decoder routing, processor lines ignored");
      in_v = in_v | 18'h00028;
      idle(3);
      rreg(4'd0, 8'h07, "R6", "decoder lines on vectors 1 and 2");

      // R7: sync selection and inversion
      settle();
      wreg(4'd4, 8'h08);
      clear_all();
      in_v = 18'h00140;
      idle(3);
      rreg(4'd0, 8'h08, "R7", "decoder sync selected");
      settle();
      wreg(4'd4, 8'h0C);
      clear_all();
      in_v = 18'h00200;
      idle(3);
      rreg(4'd0, 8'h08, "R7", "bus detect selected");
      settle();
      wreg(4'd4, 8'h18);
      clear_all();
      in_v = 18'h00100;
      idle(3);
      rreg(4'd0, 8'h00, "R7", "inverted sync on rising input");
      in_v = '0;
      idle(3);
      rreg(4'd0, 8'h08, "R7", "inverted sync on falling input");

      // R8: error routing
      settle();
      wreg(4'd4, 8'hA0);
      clear_all();
      in_v = 18'h05C00;
      idle(3);
      rreg(4'd0, 8'h10, "R8", "line-buffer error on matching field");
      settle();
      wreg(4'd4, 8'h20);
      clear_all();
      in_v = 18'h06000;
      idle(3);
      rreg(4'd0, 8'h00, "R8", "line-buffer error on other field");
      settle();
      wreg(4'd4, 8'h40);
      clear_all();
      in_v = 18'h08000;
      idle(3);
      rreg(4'd0, 8'h20, "R8", "extra processor error on vector 5");

      // R9: lock gating and auxiliary
      settle();
      wreg(4'd4, 8'h00);
      clear_all();
      in_v = 18'h10000;
      idle(3);
      rreg(4'd0, 8'h00, "R9", "lock ignored while disabled");
      in_v = '0;
      wreg(4'd5, 8'h01);
      idle(3);
      clear_all();
      in_v = 18'h30000;
      idle(3);
      rreg(4'd0, 8'hC0, "R9", "lock and auxiliary vectors");

      // R4: mask and polarity
      settle();
      clear_all();
      wreg(4'd1, 8'h01);
      in_v = 18'h00001;
      idle(3);
      pin_is(1'b0, "R4", "masked flag hidden");
      rreg(4'd0, 8'h01, "R4", "masked flag still set");
      wreg(4'd1, 8'h00);
      pin_is(1'b0, "R4", "pin at unmask edge");
      idle(1);
      pin_is(1'b1, "R4", "pin after unmask");
      wreg(4'd3, 8'h02);
      pin_is(1'b1, "R4", "pin at polarity edge");
      idle(1);
      pin_is(1'b0, "R4", "active-low level");
      wreg(4'd3, 8'h00);

      // R5: pulse signalling
      settle();
      clear_all();
      wreg(4'd3, 8'h01);
      in_v = 18'h00001;
      idle(2); pin_is(1'b0, "R5", "idle before pulse");
      idle(1); pin_is(1'b1, "R5", "high pulse");
      idle(1); pin_is(1'b0, "R5", "pulse lasts one clock");
      wreg(4'd3, 8'h03);
      clear_all();
      idle(1); pin_is(1'b1, "R5", "falling-mode idle high");
      in_v = 18'h00003;
      idle(2); pin_is(1'b1, "R5", "idle before low pulse");
      idle(1); pin_is(1'b0, "R5", "low pulse");
      idle(1); pin_is(1'b1, "R5", "low pulse lasts one clock");
      wreg(4'd3, 8'h00);

      // R10: read-only flags, padding, empty addresses
      clear_all();
      wreg(4'd0, 8'hFF);
      rreg(4'd0, 8'h00, "R10", "flag write ignored");
      rreg(4'd6, 8'h00, "R10", "address 6");
      rreg(4'd7, 8'h00, "R10", "address 7");
      rreg(4'd15, 8'h00, "R10", "address 15");
      wreg(4'd3, 8'hFF);
      rreg(4'd3, 8'h03, "R10", "pin register padding");
      wreg(4'd3, 8'h00);
      wreg(4'd5, 8'hFE);
      rreg(4'd5, 8'h00, "R10", "lock register padding");

      // constrained random against the cycle model
      for (int k = 0; k < 3000; k++) begin
         t32  = $urandom & $urandom;
         flip = t32[17:0];
         in_v = in_v ^ flip;
         t32  = $urandom;
         w    = (t32[2:0] == 3'd0);
         r    = t32[3];
         a    = t32[4] ? t32[8:5] : {1'b0, t32[7:5]};
         d    = t32[16:9];
         if (w && a == 4'd2) d = d | t32[24:17];
         if (w && a == 4'd1) d = d & t32[24:17];
         step(w, r, a, d);
      end

      finish_up();
   end
endmodule